// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block decides which of up to sixty interrupt levels a 16-bit minicomputer services next. Each level has a vector code equal to its channel number. The codes run from 4 to 63 (octal 04 to 77), and a smaller code always has higher priority. Level 4 is power fail and level 5 is parity error or memory protect. Levels 6 and 7 are the two block-transfer completions, and levels 8 to 63 are I/O device channels.

Every channel from 6 up has a control flip-flop, a flag flip-flop and a pending bit. A channel whose flag and control are both set forms a link in a priority chain, and that link shuts out every lower channel until its flag is cleared. The CPU sequencer drives the controller with these inputs:
- a machine-cycle-end strobe and a phase-end strobe;
- the I/O instruction currently executing (operation and select code);
- indications of an indirect jump in progress and of a block transfer in progress.

The controller grants only on the cycle-end strobe, and it applies the inhibit windows those inputs imply. It issues the winning vector and keeps the most recent one for software to read back.

Top module: `vpic_top`

## Requirements
- R1: When several levels are eligible at the same strobe, the lowest vector code wins. `vecOut` carries the vector code itself: 4 for power fail, 5 for parity, and channel n gives n (bit `chanReq[i]` belongs to code i+6).
- R2: Grants are decided only on a cycle where `cycleEnd` is high, and at most one vector is decided per strobe. `vecValid` is high for exactly the one cycle after that strobe, with `vecOut` valid alongside it.
- R3: The global enable is clear after reset. An I/O operation STF (`ioOp`=2) to select 0 sets it, and CLF (`ioOp`=3) to select 0 clears it. Channels 6 to 63 are granted only while it is set. Power fail (code 4) is granted regardless of it.
- R4: The parity level (code 5) has its own enable, set by STF to select 5 and cleared by CLF to select 5, and the global enable does not gate it. A parity request that arrives while the enable is clear stays pending until the enable is set.
- R5: A channel whose flag and control are both set blocks every higher-numbered channel, including one whose request is pending. A CLF to that channel's select code unblocks them. A request on a lower-numbered channel is still granted while the chain link is set.
- R6: After any grant, no further grant is made until `phaseEnd` has pulsed at least twice.
- R7: A cycle with an STC (`ioOp`=0), CLC (1), STF (2) or CLF (3) defers granting. The next `cycleEnd` grants nothing, and the one after it may grant.
- R8: While `jmpInd` is high, every level except code 5 is held off. The hold lifts once `indirStep` has pulsed 3 times, or once `jmpInd` falls and then one `phaseEnd` has pulsed.
- R9: While `dmaBusy` is high, no level is granted, power fail included.
- R10: A read (`ioOp`=4) to select 4 returns the most recent vector on `rdData`, zero-extended. After reset it returns 0, and a read at any other select code returns 0.
- R11: Once power fail is granted, codes 5 to 63 are inhibited until an STC to select 4. A further power-fail request is still granted in the meantime.
- R12: For channels 6 to 63:
  - STC and CLC to the channel's select code set and clear its control flip-flop.
  - A device pulse on `chanReq` or an STF sets its flag and its pending bit.
  - A grant clears the pending bit, so one request event is served once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cycleEnd | input | 1 | End-of-machine-cycle strobe; the grant point |
| phaseEnd | input | 1 | End-of-phase strobe |
| ioValid | input | 1 | An I/O instruction executes this cycle |
| ioOp | input | 3 | 0 STC, 1 CLC, 2 STF, 3 CLF, 4 read |
| ioSel | input | 6 | Select code of the I/O instruction |
| rdData | output | 16 | Read data for select 4 reads |
| pfReq | input | 1 | Power-fail request pulse |
| parReq | input | 1 | Parity/protect request pulse |
| chanReq | input | 58 | Device request pulses; bit i is code i+6 |
| jmpInd | input | 1 | Indirect jump or subroutine jump in progress |
| indirStep | input | 1 | One indirect level resolved |
| dmaBusy | input | 1 | Block transfer in progress |
| vecValid | output | 1 | Vector issued (one-cycle pulse) |
| vecOut | output | 6 | Issued vector code |

## Verification
Several kinds of contention are tried at a single strobe:
- two channels pending at once, which tells apart a lowest-code selection from an arbitrary one;
- power fail and parity against channels, which shows the special levels bypass or respect the global enable as intended;
- a lower channel behind a serviced higher one, and a higher channel above a serviced lower one, which separates the chain blocking from plain priority.

Each inhibit window is opened and then closed by its own release event: phase counts, a deferring I/O operation, an indirect chain ended by count or by a falling edge, and a block transfer. This shows that exactly the right strobe is suppressed and the following one grants.

// File: rtl/vpic_pkg.sv
package vpic_pkg;
  localparam int VEC_W = 6;

  typedef enum logic [2:0] {
    OP_STC = 3'd0,
    OP_CLC = 3'd1,
    OP_STF = 3'd2,
    OP_CLF = 3'd3,
    OP_RDV = 3'd4
  } ioOp_e;

  typedef struct packed {
    logic             evalMain;
    logic             evalPar;
    logic             globalEn;
    logic             parEn;
    logic             pfActive;
    logic             chanSetCtl;
    logic             chanClrCtl;
    logic             chanSetFlag;
    logic             chanClrFlag;
    logic [VEC_W-1:0] chanSel;
    logic             rdLast;
  } strobes_t;
endpackage

// File: rtl/vpic_ctrl.sv
module vpic_ctrl
  import vpic_pkg::*;
#(
  parameter int FIRST_VEC   = 4,
  parameter int HOLD_PHASES = 2,
  parameter int IND_LIMIT   = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cycleEnd,
  input  logic             phaseEnd,
  input  logic             ioValid,
  input  logic [2:0]       ioOp,
  input  logic [VEC_W-1:0] ioSel,
  input  logic             jmpInd,
  input  logic             indirStep,
  input  logic             dmaBusy,
  input  logic             grantFire,
  input  logic [VEC_W-1:0] grantVec,
  output strobes_t         stb
);
  localparam int HOLD_W = $clog2(HOLD_PHASES + 1);
  localparam int IND_W  = $clog2(IND_LIMIT + 1);
  localparam logic [VEC_W-1:0] SEL_GLOBAL = '0;
  localparam logic [VEC_W-1:0] SEL_PF     = VEC_W'(FIRST_VEC);
  localparam logic [VEC_W-1:0] SEL_PAR    = VEC_W'(FIRST_VEC + 1);

  logic isStc, isClc, isStf, isClf, isRd, ctlNow;
  logic globalEn, parEn, pfActive;
  logic [HOLD_W-1:0] holdCnt;
  logic deferArm;
  logic [IND_W-1:0] indCnt;
  logic jmpIndQ, tailHold, indFall, indHold, baseHold;

  assign isStc  = ioValid && (ioOp == OP_STC);
  assign isClc  = ioValid && (ioOp == OP_CLC);
  assign isStf  = ioValid && (ioOp == OP_STF);
  assign isClf  = ioValid && (ioOp == OP_CLF);
  assign isRd   = ioValid && (ioOp == OP_RDV);
  assign ctlNow = isStc || isClc || isStf || isClf;

  // enables and power-fail re-arm
  always_ff @(posedge clk) begin
    if (!rstN) begin
      globalEn <= 1'b0;
      parEn    <= 1'b0;
      pfActive <= 1'b0;
    end else begin
      if (isStf && ioSel == SEL_GLOBAL)      globalEn <= 1'b1;
      else if (isClf && ioSel == SEL_GLOBAL) globalEn <= 1'b0;
      if (isStf && ioSel == SEL_PAR)         parEn <= 1'b1;
      else if (isClf && ioSel == SEL_PAR)    parEn <= 1'b0;
      if (grantFire && grantVec == SEL_PF)   pfActive <= 1'b1;
      else if (isStc && ioSel == SEL_PF)     pfActive <= 1'b0;
    end
  end

  // post-grant phase holdoff and control-instruction deferral
  always_ff @(posedge clk) begin
    if (!rstN) begin
      holdCnt  <= '0;
      deferArm <= 1'b0;
    end else begin
      if (grantFire)                        holdCnt <= HOLD_W'(HOLD_PHASES);
      else if (phaseEnd && holdCnt != '0)   holdCnt <= holdCnt - 1'b1;
      if (cycleEnd)                         deferArm <= 1'b0;
      else if (ctlNow)                      deferArm <= 1'b1;
    end
  end

  // indirect jump window
  always_ff @(posedge clk) begin
    if (!rstN) begin
      indCnt   <= '0;
      jmpIndQ  <= 1'b0;
      tailHold <= 1'b0;
    end else begin
      jmpIndQ <= jmpInd;
      if (!jmpInd)                                     indCnt <= '0;
      else if (indirStep && indCnt < IND_W'(IND_LIMIT)) indCnt <= indCnt + 1'b1;
      if (indFall)       tailHold <= 1'b1;
      else if (phaseEnd) tailHold <= 1'b0;
    end
  end

  assign indFall  = jmpIndQ && !jmpInd;
  assign indHold  = (jmpInd && indCnt < IND_W'(IND_LIMIT)) || tailHold || indFall;
  assign baseHold = (holdCnt != '0) || deferArm || ctlNow || dmaBusy;

  always_comb begin
    stb             = '0;
    stb.evalPar     = cycleEnd && !baseHold;
    stb.evalMain    = cycleEnd && !baseHold && !indHold;
    stb.globalEn    = globalEn;
    stb.parEn       = parEn;
    stb.pfActive    = pfActive;
    stb.chanSetCtl  = isStc;
    stb.chanClrCtl  = isClc;
    stb.chanSetFlag = isStf;
    stb.chanClrFlag = isClf;
    stb.chanSel     = ioSel;
    stb.rdLast      = isRd && ioSel == SEL_PF;
  end

  AST_GRANT_WINDOW: assert property (@(posedge clk) disable iff (!rstN)
    grantFire |-> (cycleEnd && holdCnt == '0 && !dmaBusy && !deferArm)); // R6
  AST_DMA_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    dmaBusy |-> !grantFire); // R9
endmodule

// File: rtl/vpic_datapath.sv
module vpic_datapath
  import vpic_pkg::*;
#(
  parameter int NUM_LEVELS = 60,
  parameter int FIRST_VEC  = 4,
  parameter int DATA_W     = 16
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  strobes_t              stb,
  input  logic                  pfReq,
  input  logic                  parReq,
  input  logic [NUM_LEVELS-3:0] chanReq,
  output logic                  grantFire,
  output logic [VEC_W-1:0]      grantVec,
  output logic                  vecValid,
  output logic [VEC_W-1:0]      vecOut,
  output logic [DATA_W-1:0]     rdData
);
  localparam int NUM_CHAN  = NUM_LEVELS - 2;
  localparam int CHAN_BASE = FIRST_VEC + 2;
  localparam int LVL_W     = $clog2(NUM_LEVELS);

  logic [NUM_CHAN-1:0]   flagV, ctlV, pendV, blockAbove;
  logic [NUM_LEVELS-1:0] elig;
  logic [LVL_W-1:0]      grantIdx;
  logic                  pfPend, parPend;
  logic [VEC_W-1:0]      lastVec;

  // per-channel control, flag and pending flip-flops
  for (genvar g = 0; g < NUM_CHAN; g++) begin : g_chan
    logic hit, flagR, ctlR, pendR, wonHere;
    assign hit     = stb.chanSel == VEC_W'(CHAN_BASE + g);
    assign wonHere = grantFire && grantIdx == LVL_W'(g + 2);
    always_ff @(posedge clk) begin
      if (!rstN) begin
        flagR <= 1'b0;
        ctlR  <= 1'b0;
        pendR <= 1'b0;
      end else begin
        if (stb.chanSetCtl && hit)      ctlR <= 1'b1;
        else if (stb.chanClrCtl && hit) ctlR <= 1'b0;
        if (stb.chanClrFlag && hit) begin
          flagR <= 1'b0;
          pendR <= 1'b0;
        end else if (chanReq[g] || (stb.chanSetFlag && hit)) begin
          flagR <= 1'b1;
          pendR <= 1'b1;
        end else if (wonHere) begin
          pendR <= 1'b0;
        end
      end
    end
    assign flagV[g] = flagR;
    assign ctlV[g]  = ctlR;
    assign pendV[g] = pendR;
    assign elig[g + 2] = pendR && flagR && ctlR && stb.globalEn && !stb.pfActive
                         && !blockAbove[g] && stb.evalMain;
  end

  // priority chain: a serviced channel blocks all below it
  always_comb begin
    logic acc;
    acc = 1'b0;
    for (int i = 0; i < NUM_CHAN; i++) begin
      blockAbove[i] = acc;
      acc = acc | (flagV[i] & ctlV[i]);
    end
  end

  assign elig[0] = pfPend && stb.evalMain;
  assign elig[1] = parPend && stb.parEn && !stb.pfActive && stb.evalPar;

  always_comb begin
    grantIdx = '0;
    for (int i = NUM_LEVELS - 1; i >= 0; i--) begin
      if (elig[i]) grantIdx = LVL_W'(i);
    end
  end

  assign grantFire = |elig;
  assign grantVec  = VEC_W'(grantIdx) + VEC_W'(FIRST_VEC);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pfPend   <= 1'b0;
      parPend  <= 1'b0;
      vecValid <= 1'b0;
      vecOut   <= '0;
      lastVec  <= '0;
    end else begin
      if (pfReq)                              pfPend <= 1'b1;
      else if (grantFire && grantIdx == '0)   pfPend <= 1'b0;
      if (parReq)                             parPend <= 1'b1;
      else if (grantFire && grantIdx == LVL_W'(1)) parPend <= 1'b0;
      vecValid <= grantFire;
      if (grantFire) begin
        vecOut  <= grantVec;
        lastVec <= grantVec;
      end
    end
  end

  assign rdData = stb.rdLast ? DATA_W'(lastVec) : '0;

  AST_PF_INHIBIT: assert property (@(posedge clk) disable iff (!rstN)
    (grantFire && grantIdx != '0) |-> !stb.pfActive); // R11
  AST_GLOBAL_GATE: assert property (@(posedge clk) disable iff (!rstN)
    (grantFire && grantIdx > LVL_W'(1)) |-> stb.globalEn); // R3
  AST_PAR_GATE: assert property (@(posedge clk) disable iff (!rstN)
    (grantFire && grantIdx == LVL_W'(1)) |-> stb.parEn); // R4
  AST_VEC_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    vecValid |-> (vecOut >= VEC_W'(FIRST_VEC))); // R1
  AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    vecValid |=> !vecValid); // R6
endmodule

// File: rtl/vpic_top.sv
module vpic_top
  import vpic_pkg::*;
#(
  parameter int NUM_LEVELS  = 60,
  parameter int FIRST_VEC   = 4,
  parameter int DATA_W      = 16,
  parameter int HOLD_PHASES = 2,
  parameter int IND_LIMIT   = 3
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  cycleEnd,
  input  logic                  phaseEnd,
  input  logic                  ioValid,
  input  logic [2:0]            ioOp,
  input  logic [VEC_W-1:0]      ioSel,
  output logic [DATA_W-1:0]     rdData,
  input  logic                  pfReq,
  input  logic                  parReq,
  input  logic [NUM_LEVELS-3:0] chanReq,
  input  logic                  jmpInd,
  input  logic                  indirStep,
  input  logic                  dmaBusy,
  output logic                  vecValid,
  output logic [VEC_W-1:0]      vecOut
);
  strobes_t         stb;
  logic             grantFire;
  logic [VEC_W-1:0] grantVec;

  vpic_ctrl #(
    .FIRST_VEC(FIRST_VEC), .HOLD_PHASES(HOLD_PHASES), .IND_LIMIT(IND_LIMIT)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .cycleEnd(cycleEnd), .phaseEnd(phaseEnd),
    .ioValid(ioValid), .ioOp(ioOp), .ioSel(ioSel), .jmpInd(jmpInd),
    .indirStep(indirStep), .dmaBusy(dmaBusy), .grantFire(grantFire),
    .grantVec(grantVec), .stb(stb)
  );

  vpic_datapath #(
    .NUM_LEVELS(NUM_LEVELS), .FIRST_VEC(FIRST_VEC), .DATA_W(DATA_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .pfReq(pfReq), .parReq(parReq),
    .chanReq(chanReq), .grantFire(grantFire), .grantVec(grantVec),
    .vecValid(vecValid), .vecOut(vecOut), .rdData(rdData)
  );

  AST_VEC_ON_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    vecValid |-> $past(cycleEnd)); // R2
endmodule

// File: tb/vpic_top_tb.sv
module vpic_top_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 58;

  logic clk = 1'b0;
  logic rstN, cycleEnd, phaseEnd, ioValid, pfReq, parReq, jmpInd, indirStep, dmaBusy;
  logic [2:0] ioOp;
  logic [5:0] ioSel;
  logic [NCH-1:0] chanReq;
  logic [15:0] rdData;
  logic vecValid;
  logic [5:0] vecOut;
  int checks = 0;
  int failures = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  vpic_top u_dut (
    .clk(clk), .rstN(rstN), .cycleEnd(cycleEnd), .phaseEnd(phaseEnd),
    .ioValid(ioValid), .ioOp(ioOp), .ioSel(ioSel), .rdData(rdData),
    .pfReq(pfReq), .parReq(parReq), .chanReq(chanReq), .jmpInd(jmpInd),
    .indirStep(indirStep), .dmaBusy(dmaBusy), .vecValid(vecValid), .vecOut(vecOut)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; cycleEnd = 0; phaseEnd = 0; ioValid = 0; ioOp = 0; ioSel = 0;
    pfReq = 0; parReq = 0; chanReq = '0; jmpInd = 0; indirStep = 0; dmaBusy = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic ioCmd(input int op, input int sel);
    @(negedge clk);
    ioValid = 1'b1; ioOp = 3'(op); ioSel = 6'(sel);
    @(negedge clk);
    ioValid = 1'b0;
  endtask

  task automatic readVec(input int sel, output int val);
    @(negedge clk);
    ioValid = 1'b1; ioOp = 3'd4; ioSel = 6'(sel);
    #1 val = int'(rdData);
    @(negedge clk);
    ioValid = 1'b0;
  endtask

  task automatic phase();
    @(negedge clk); phaseEnd = 1'b1;
    @(negedge clk); phaseEnd = 1'b0;
  endtask

  // returns vector code, or -1 when nothing issued
  task automatic strobe(output int v);
    @(negedge clk); cycleEnd = 1'b1;
    @(negedge clk); cycleEnd = 1'b0;
    v = vecValid ? int'(vecOut) : -1;
  endtask

  task automatic settle();
    int d;
    strobe(d);
    phase(); phase();
  endtask

  task automatic chanPulse(input int code);
    @(negedge clk); chanReq[code - 6] = 1'b1;
    @(negedge clk); chanReq = '0;
  endtask

  task automatic pfPulse();
    @(negedge clk); pfReq = 1'b1;
    @(negedge clk); pfReq = 1'b0;
  endtask

  task automatic parPulse();
    @(negedge clk); parReq = 1'b1;
    @(negedge clk); parReq = 1'b0;
  endtask

  task automatic testResetAndGlobal();
    int v;
    doReset();
    @(negedge clk);
    chk("R2 reset vecValid", int'(vecValid), 0);
    readVec(4, v); chk("R10 reset readback", v, 0);
    ioCmd(0, 10); settle();
    chanPulse(10);
    strobe(v); chk("R3 global enable clear after reset", v, -1);
    ioCmd(2, 0); settle();
    strobe(v); chk("R3 granted after STF 0", v, 10);
  endtask

  task automatic testBasic();
    int v;
    doReset();
    ioCmd(2, 0); settle();
    ioCmd(0, 20); settle();
    chanPulse(20);
    strobe(v); chk("R12 device pulse granted", v, 20);
    readVec(4, v); chk("R10 last vector readback", v, 20);
    readVec(5, v); chk("R10 other select reads zero", v, 0);
    phase(); phase();
    strobe(v); chk("R12 no regrant of served event", v, -1);
    ioCmd(0, 19); settle();
    ioCmd(2, 19); settle();
    strobe(v); chk("R12 STF sets flag and pending", v, 19);
  endtask

  task automatic testPriorityChain();
    int v;
    doReset();
    ioCmd(2, 0); settle();
    ioCmd(0, 10); settle();
    ioCmd(0, 11); settle();
    @(negedge clk); chanReq[4] = 1'b1; chanReq[5] = 1'b1;
    @(negedge clk); chanReq = '0;
    strobe(v); chk("R1 lowest code wins", v, 10);
    phase(); phase();
    strobe(v); chk("R5 lower channel blocked by chain", v, -1);
    ioCmd(3, 10); settle();
    strobe(v); chk("R5 unblocked after CLF", v, 11);
    phase(); phase();
    chanPulse(10);
    strobe(v); chk("R5 higher channel nests over serviced", v, 10);
  endtask

  task automatic testParity();
    int v;
    doReset();
    ioCmd(2, 5); settle();
    parPulse();
    strobe(v); chk("R4 parity without global enable", v, 5);
    phase(); phase();
    ioCmd(3, 5); settle();
    parPulse();
    strobe(v); chk("R4 parity masked by own enable", v, -1);
    ioCmd(2, 5); settle();
    strobe(v); chk("R4 parity pending kept", v, 5);
  endtask

  task automatic testPowerFail();
    int v;
    doReset();
    ioCmd(2, 5); settle();
    ioCmd(0, 10); settle();
    pfPulse(); parPulse();
    strobe(v); chk("R3 R1 power fail ungated and first", v, 4);
    ioCmd(2, 0); settle();
    chanPulse(10);
    strobe(v); chk("R11 lower levels inhibited", v, -1);
    pfPulse();
    strobe(v); chk("R11 power fail regranted", v, 4);
    phase(); phase();
    ioCmd(0, 4); settle();
    strobe(v); chk("R11 re-armed parity next", v, 5);
    phase(); phase();
    strobe(v); chk("R11 channel after re-arm", v, 10);
  endtask

  task automatic testHoldoff();
    int v;
    doReset();
    ioCmd(2, 0); settle();
    ioCmd(0, 10); settle();
    ioCmd(0, 11); settle();
    chanPulse(11);
    strobe(v); chk("R6 first grant", v, 11);
    chanPulse(10);
    phase();
    strobe(v); chk("R6 held after one phase", v, -1);
    phase();
    strobe(v); chk("R6 released after two phases", v, 10);
  endtask

  task automatic testDefer();
    int v;
    doReset();
    ioCmd(2, 0); settle();
    ioCmd(0, 10); settle();
    chanPulse(10);
    ioCmd(0, 30);
    strobe(v); chk("R7 deferred strobe", v, -1);
    strobe(v); chk("R7 following strobe grants", v, 10);
  endtask

  task automatic testIndirect();
    int v;
    doReset();
    ioCmd(2, 0); settle();
    ioCmd(2, 5); settle();
    ioCmd(0, 10); settle();
    @(negedge clk); jmpInd = 1'b1;
    chanPulse(10); parPulse();
    strobe(v); chk("R8 parity exempt from indirect hold", v, 5);
    phase(); phase();
    strobe(v); chk("R8 channel held during indirect", v, -1);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); indirStep = 1'b1;
      @(negedge clk); indirStep = 1'b0;
    end
    strobe(v); chk("R8 released after three levels", v, 10);
    @(negedge clk); jmpInd = 1'b0;
    doReset();
    ioCmd(2, 0); settle();
    ioCmd(0, 10); settle();
    @(negedge clk); jmpInd = 1'b1;
    repeat (2) @(negedge clk);
    jmpInd = 1'b0;
    chanPulse(10);
    strobe(v); chk("R8 held until phase after end", v, -1);
    phase();
    strobe(v); chk("R8 released after one phase", v, 10);
  endtask

  task automatic testDma();
    int v;
    doReset();
    pfPulse();
    @(negedge clk); dmaBusy = 1'b1;
    strobe(v); chk("R9 held while transfer busy", v, -1);
    @(negedge clk); dmaBusy = 1'b0;
    strobe(v); chk("R9 granted after transfer", v, 4);
  endtask

  task automatic testStrobeOnly();
    int v;
    int seen;
    doReset();
    ioCmd(2, 0); settle();
    ioCmd(0, 10); settle();
    chanPulse(10);
    seen = 0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (vecValid) seen++;
    end
    chk("R2 no grant without strobe", seen, 0);
    strobe(v); chk("R2 grant on strobe", v, 10);
    @(negedge clk);
    chk("R2 vecValid single cycle", int'(vecValid), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    testResetAndGlobal();
    testBasic();
    testPriorityChain();
    testParity();
    testPowerFail();
    testHoldoff();
    testDefer();
    testIndirect();
    testDma();
    testStrobeOnly();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule